// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a serial stereo audio stream into parallel sample words. It runs directly on the bit clock. The incoming frame clock divides every frame into a left half and a right half. Serial data is sampled on each rising bit-clock edge, most significant bit first, in two's complement. A 3-bit format code selects one of five word layouts:

- **MSB-justified:** the word starts at the frame-clock transition.
- **I2S-style:** the word starts one bit clock after the transition.
- **LSB-justified (three widths):** the word ends on the last bit before the next transition.

Each stereo pair is presented as two 24-bit words with the sign in bit 23. The left and right words change together, and a one-cycle strobe marks each new pair. A half-frame may carry more bit clocks than the word needs. The extra slots are skipped: after the word in the MSB-justified and I2S layouts, and before it in the LSB-justified layouts.

Top module: `audio_serial_rx`

## Requirements
- R1: While `rst_n` is low, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: With `fmt` = 3'b010, the 24 bits sampled starting at the rising edge that first sees the new frame-clock level form the word. A high frame clock marks the left half.
- R3: With `fmt` = 3'b011, the word starts one bit clock after the frame-clock change, and a low frame clock marks the left half. A 24-bit-clock half works, with its last bit sampled at the next half's first edge.
- R4: With `fmt` = 3'b100, the last 24 bits sampled before the frame-clock change form the word. A high frame clock marks the left half.
- R5: With `fmt` = 3'b000, the last 16 bits before the frame-clock change are output in bits 23:8, and bits 7:0 are zero.
- R6: With `fmt` = 3'b001, the last 20 bits before the frame-clock change are output in bits 23:4, and bits 3:0 are zero.
- R7: `valid_o` is high for exactly one cycle per frame. It rises on the rising bit-clock edge at which the frame clock is first seen leaving the right half. `left_o` and `right_o` change only on that edge.
- R8: Bit clocks beyond the word length in a half-frame have no effect on the output words, whatever data they carry.
- R9: Format codes 3'b101, 3'b110 and 3'b111 behave exactly like 3'b010.
- R10: After reset, no pair is reported until a complete left half has been received. A right half cut short by reset never produces a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; data sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lrck | input | 1 | Frame clock selecting left or right half |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt | input | 3 | Word layout select |
| left_o | output | 24 | Left sample, sign in bit 23 |
| right_o | output | 24 | Right sample, sign in bit 23 |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
Two kinds of internal fault show up at the ports within one frame:

- **Wrong bit counter or tail register:** the next strobe carries a word shifted by one or more places, or with nonzero padding bits.
- **Wrong channel polarity or frame-edge detection:** left and right appear swapped, or the strobe arrives a half-frame early or late. It may also be missing from the first frame after reset.

Each pair is compared with words built arithmetically. These include full-scale negative, full-scale positive, zero and all-ones values, so any misplacement of a single bit is caught at the strobe that follows.

// File: rtl/audio_serial_rx.sv
module audio_serial_rx (
  input  logic        bclk,
  input  logic        rst_n,
  input  logic        lrck,
  input  logic        sdata,
  input  logic [2:0]  fmt,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o
);
  localparam int W  = 24;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic          lr_q, started, have_left;
  logic [CW-1:0] cnt;
  logic [W-1:0]  acc, tail, hold_l, word;
  logic          i2s_mode, frame_edge, left_done;

  assign i2s_mode   = (fmt == 3'b011);
  assign frame_edge = started && (lrck != lr_q);
  assign left_done  = i2s_mode ? !lr_q : lr_q;

  always_comb begin
    case (fmt)
      3'b000:  word = {tail[15:0], 8'b0};
      3'b001:  word = {tail[19:0], 4'b0};
      3'b100:  word = tail;
      3'b011:  word = (cnt < FULL) ? {acc[W-2:0], sdata} : acc;
      default: word = acc;
    endcase
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q      <= 1'b0;
      started   <= 1'b0;
      have_left <= 1'b0;
      cnt       <= '0;
      acc       <= '0;
      tail      <= '0;
      hold_l    <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      started <= 1'b1;
      lr_q    <= lrck;
      tail    <= {tail[W-2:0], sdata};
      valid_o <= 1'b0;
      if (frame_edge) begin
        cnt <= i2s_mode ? '0 : CW'(1);
        acc <= i2s_mode ? '0 : {{(W-1){1'b0}}, sdata};
        if (left_done) begin
          hold_l    <= word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o  <= hold_l;
          right_o <= word;
          valid_o <= 1'b1;
        end
      end else if (cnt < FULL) begin
        cnt <= cnt + 1'b1;
        acc <= {acc[W-2:0], sdata};
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk (
  input logic        bclk,
  input logic        rst_n,
  input logic        lrck,
  input logic [2:0]  fmt,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        valid_o
);
  AST_RESET_CLEAR: assert property (@(posedge bclk)
    !rst_n |-> (left_o == 24'd0 && right_o == 24'd0 && !valid_o)); // R1

  AST_STROBE_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R7

  AST_HOLD_BETWEEN: assert property (@(posedge bclk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7

  AST_STROBE_ON_EDGE: assert property (@(posedge bclk) disable iff (!rst_n)
    valid_o |-> ($past(lrck) != $past(lrck, 2))); // R7

  AST_PAD_ZERO_16: assert property (@(posedge bclk) disable iff (!rst_n)
    (valid_o && $past(fmt) == 3'b000) |-> (left_o[7:0] == 8'd0 && right_o[7:0] == 8'd0)); // R5

  AST_PAD_ZERO_20: assert property (@(posedge bclk) disable iff (!rst_n)
    (valid_o && $past(fmt) == 3'b001) |-> (left_o[3:0] == 4'd0 && right_o[3:0] == 4'd0)); // R6
endmodule

bind audio_serial_rx audio_serial_rx_chk u_chk (
  .bclk(bclk), .rst_n(rst_n), .lrck(lrck), .fmt(fmt),
  .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/audio_serial_rx_bench.sv
`timescale 1ns/1ps
module audio_serial_rx_bench;
  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrck = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmt = 3'b010;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int    checks = 0;
  int    fails = 0;
  int    got_n = 0;
  int    nbits = 24;
  bit    mon_on = 1'b0;
  bit    hold_bad = 1'b0;
  bit    done = 1'b0;
  string tag = "";
  logic [23:0] last_l = '0, last_r = '0;

  audio_serial_rx u_audio_serial_rx (
    .bclk(bclk), .rst_n(rst_n), .lrck(lrck), .sdata(sdata), .fmt(fmt),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #10 bclk = ~bclk;

  function automatic logic [23:0] val(int k, int ch, int n);
    logic [31:0] x;
    logic [31:0] m;
    m = (32'h1 << n) - 32'h1;
    if (k == 0)      x = (ch != 0) ? ((32'h1 << (n - 1)) - 32'h1) : (32'h1 << (n - 1));
    else if (k == 1) x = (ch != 0) ? 32'h0 : 32'hFFFF_FFFF;
    else             x = (32'(k) * 32'h9E37_79B1 + 32'(ch) * 32'h7F4A_7C15) >> 5;
    return 24'(x & m);
  endfunction

  function automatic logic junk(int a, int b);
    return ((a * 5 + b * 3 + 1) & 1) != 0;
  endfunction

  always @(negedge bclk) begin
    if (rst_n && mon_on) begin
      if (valid_o) begin
        logic [23:0] el, er;
        el = val(got_n, 0, nbits) << (24 - nbits);
        er = val(got_n, 1, nbits) << (24 - nbits);
        checks++;
        if (left_o !== el || right_o !== er) begin
          fails++;
          $display("FAIL %s pair %0d: got L=%h R=%h expected L=%h R=%h",
                   tag, got_n, left_o, right_o, el, er);
        end
        got_n++;
      end else if (left_o !== last_l || right_o !== last_r) begin
        hold_bad = 1'b1;
      end
      last_l = left_o;
      last_r = right_o;
    end
  end

  task automatic run(input logic [2:0] f, input int h, input int nf, input string t);
    int n;
    logic lvl_left, carry, b;
    logic [23:0] w;
    n = (f == 3'b000) ? 16 : (f == 3'b001) ? 20 : 24;
    lvl_left = (f == 3'b011) ? 1'b0 : 1'b1;
    @(negedge bclk);
    rst_n = 1'b0; mon_on = 1'b0; fmt = f; lrck = !lvl_left; sdata = 1'b0;
    repeat (3) @(negedge bclk);
    checks++;
    if (left_o !== 24'd0 || right_o !== 24'd0 || valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset (%s): got L=%h R=%h V=%b expected 0 0 0", t, left_o, right_o, valid_o);
    end
    nbits = n; tag = t; got_n = 0; hold_bad = 1'b0; last_l = '0; last_r = '0;
    rst_n = 1'b1; mon_on = 1'b1;
    repeat (3) @(negedge bclk);
    carry = 1'b0;
    for (int k = 0; k < nf; k++) begin
      for (int ch = 0; ch < 2; ch++) begin
        w = val(k, ch, n);
        for (int s = 0; s < h; s++) begin
          @(negedge bclk);
          lrck = (ch == 0) ? lvl_left : !lvl_left;
          if (f == 3'b011) begin
            if (s == 0)       b = carry;
            else if (s <= 24) b = w[24 - s];
            else              b = junk(s, k);
          end else if (f == 3'b000 || f == 3'b001 || f == 3'b100) begin
            if (s >= h - n) b = w[n - 1 - (s - (h - n))];
            else            b = junk(s, k);
          end else begin
            b = (s < 24) ? w[23 - s] : junk(s, k);
          end
          sdata = b;
        end
        carry = (f == 3'b011 && h == 24) ? w[0] : junk(k, ch);
      end
    end
    @(negedge bclk);
    lrck = lvl_left; sdata = carry;
    repeat (4) @(negedge bclk);
    mon_on = 1'b0;
    checks++;
    if (got_n != nf) begin
      fails++;
      $display("FAIL R7 R10 strobe count (%s): got %0d expected %0d", t, got_n, nf);
    end
    checks++;
    if (hold_bad) begin
      fails++;
      $display("FAIL R7 outputs moved without strobe (%s): got 1 expected 0", t);
    end
  endtask

  initial begin
    repeat (2) @(negedge bclk);
    checks++;
    if (left_o !== 24'd0 || right_o !== 24'd0 || valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 initial reset: got L=%h R=%h V=%b expected 0 0 0", left_o, right_o, valid_o);
    end
    run(3'b000, 16, 10, "R5 lsb16 32fs");
    run(3'b000, 32, 10, "R5 R8 lsb16 64fs");
    run(3'b001, 20, 10, "R6 lsb20 40fs");
    run(3'b001, 32, 10, "R6 R8 lsb20 64fs");
    run(3'b010, 24, 10, "R2 msb 48fs");
    run(3'b010, 32, 10, "R2 R8 msb 64fs");
    run(3'b011, 24, 10, "R3 i2s 48fs");
    run(3'b011, 32, 10, "R3 R8 i2s 64fs");
    run(3'b100, 24, 10, "R4 lsb24 48fs");
    run(3'b100, 32, 10, "R4 R8 lsb24 64fs");
    run(3'b101, 32, 6,  "R9 code5");
    run(3'b110, 32, 6,  "R9 code6");
    run(3'b111, 24, 6,  "R9 code7");
    run(3'b010, 64, 6,  "R8 msb 128fs");
    run(3'b000, 64, 6,  "R8 lsb16 128fs");
    run(3'b011, 40, 6,  "R8 i2s 80fs");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule